// File: doc/BRIEF.md
# Wire-to-Message Interrupt Node

This block turns up to 128 wired interrupt lines into posted message writes. Each pin is sampled every clock and watched for either a high level or a rising edge, as software chooses per pin. A pin that fires becomes pending. A round-robin arbiter then picks one pending pin at a time and places a message on a valid/ready output. The message carries the pin's programmed device ID and event ID, so a downstream translator can route it.

Once a pin has sent its message it is held in flight and stays silent until software writes a one to its bit in the clear window. A small register port holds the per-pin trigger-type bits, one 32-bit vector word per pin, and the write-one-to-clear words. The port uses byte offsets within the node's 4 KiB window, and the node base is decoded outside the block.

Top module: `msgint_node`

## Requirements
- R1: After reset every trigger-type bit and every vector word reads 0, no pin is pending or in flight, and `msg_valid` is low.
- R2: Pin p's trigger type is bit (p mod 32) of the word at byte offset 0x000 + (p/32)*4. A 1 selects level-high and a 0 selects rising edge. The word reads back as written.
- R3: Pin p's vector word sits at byte offset 0x200 + 4*p. Bits [21:12] hold the 10-bit event ID and bits [11:0] hold the 12-bit device ID. Bits [21:0] read back exactly as written, and bits [31:22] read 0.
- R4: A message presents `msg_dev_id` and `msg_evt_id` taken from the chosen pin's vector word. While `msg_valid` is high and `msg_ready` is low, valid and payload hold unchanged.
- R5: An edge-type pin sends exactly one message per rising edge, even if the input then stays high.
- R6: A pin that has sent a message sends nothing more until it is cleared. Edges seen in that time are discarded.
- R7: Clear words sit at byte offset 0xA00 + (p/32)*4, with pin p at bit (p mod 32). Writing 1 clears that pin's pending and in-flight state, writing 0 leaves it untouched, and reads return 0.
- R8: After a clear, a level-type pin whose input is still high sends again. An edge-type pin sends again only after a new rising edge.
- R9: Among pending pins, the next one served is the lowest-numbered pin above the last one granted. If none is above it, the lowest pending pin is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Wired interrupt inputs, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset within the node window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Translator accepts the message |
| msg_dev_id | output | 12 | Device ID of the message |
| msg_evt_id | output | 10 | Event ID of the message |

## Verification
The hardest case to reach is round-robin order that differs from fixed priority. That order only shows when the pointer left by an earlier grant sits between the pins that are pending now. The bench first grants pin 5, then raises pins 1 and 9 in the same cycle and expects 9 before 1. Pin 1 is then the last grant, so it raises pins 0 and 3 together and expects 3 before 0. Silence checks (in flight, write of zero, edge pin still high after a clear) are made by waiting past the message latency with an empty scoreboard queue, so any stray message shows up as a miscompare.

// File: rtl/msgint_pkg.sv
package msgint_pkg;

    localparam int ADDR_W    = 12;
    localparam int DEV_W     = 12;
    localparam int EVT_W     = 10;
    localparam int TYPE_BASE = 'h000;
    localparam int VEC_BASE  = 'h200;
    localparam int CLR_BASE  = 'hA00;

    // Event ID in the upper field, so the packed layout matches bits [21:0].
    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [DEV_W-1:0] dev;
    } vec_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TYPE = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [9:0] idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] addr,
                                             input int num_pins);
        reg_dec_t d;
        int a;
        a     = int'(addr);
        d.sel = SEL_NONE;
        d.idx = '0;
        if (a >= TYPE_BASE && a < TYPE_BASE + num_pins / 8) begin
            d.sel = SEL_TYPE;
            d.idx = 10'((a - TYPE_BASE) >> 2);
        end else if (a >= VEC_BASE && a < VEC_BASE + 4 * num_pins) begin
            d.sel = SEL_VEC;
            d.idx = 10'((a - VEC_BASE) >> 2);
        end else if (a >= CLR_BASE && a < CLR_BASE + num_pins / 8) begin
            d.sel = SEL_CLR;
            d.idx = 10'((a - CLR_BASE) >> 2);
        end
        return d;
    endfunction

endpackage

// File: rtl/msgint_regs.sv
module msgint_regs
    import msgint_pkg::*;
#(
    parameter int NUM_PINS = 128
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic [NUM_PINS-1:0]         level_sel,
    output logic [NUM_PINS-1:0]         clr_hit,
    input  logic [$clog2(NUM_PINS)-1:0] sel_pin,
    output vec_t                        sel_vec
);
    localparam int NUM_WORDS = NUM_PINS / 32;
    localparam int PIN_W     = $clog2(NUM_PINS);

    reg_dec_t          dec;
    logic [PIN_W-1:0]  pidx;
    logic [NUM_PINS-1:0] type_q;
    vec_t              vec_q [NUM_PINS];

    assign dec       = decode_addr(addr, NUM_PINS);
    assign pidx      = dec.idx[PIN_W-1:0];
    assign level_sel = type_q;
    assign sel_vec   = vec_q[sel_pin];

    always_ff @(posedge clk) begin
        if (rst) begin
            type_q <= '0;
            for (int i = 0; i < NUM_PINS; i++) vec_q[i] <= '0;
        end else if (wr_en) begin
            if (dec.sel == SEL_TYPE) begin
                for (int w = 0; w < NUM_WORDS; w++)
                    if (int'(dec.idx) == w) type_q[w*32 +: 32] <= wdata;
            end else if (dec.sel == SEL_VEC) begin
                vec_q[pidx] <= wdata[21:0];
            end
        end
    end

    always_comb begin
        clr_hit = '0;
        if (wr_en && dec.sel == SEL_CLR)
            for (int w = 0; w < NUM_WORDS; w++)
                if (int'(dec.idx) == w) clr_hit[w*32 +: 32] = wdata;
    end

    always_comb begin
        rdata = '0;
        case (dec.sel)
            SEL_TYPE:
                for (int w = 0; w < NUM_WORDS; w++)
                    if (int'(dec.idx) == w) rdata = type_q[w*32 +: 32];
            SEL_VEC:  rdata = {10'b0, vec_q[pidx]};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/msgint_detect.sv
module msgint_detect #(
    parameter int NUM_PINS = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic [NUM_PINS-1:0] level_sel,
    input  logic [NUM_PINS-1:0] clr_hit,
    input  logic [NUM_PINS-1:0] grant,
    output logic [NUM_PINS-1:0] pending
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic prev_q, pend_q, busy_q, hit;

        assign hit        = level_sel[p] ? irq_in[p] : (irq_in[p] & ~prev_q);
        assign pending[p] = pend_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
                busy_q <= 1'b0;
            end else begin
                prev_q <= irq_in[p];
                if (clr_hit[p]) begin
                    pend_q <= 1'b0;
                    busy_q <= 1'b0;
                end else if (grant[p]) begin
                    pend_q <= 1'b0;
                    busy_q <= 1'b1;
                end else if (!busy_q && hit) begin
                    pend_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/msgint_rr_arb.sv
module msgint_rr_arb #(
    parameter int NUM_PINS = 128,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] req,
    input  logic                advance,
    output logic [NUM_PINS-1:0] grant,
    output logic [PIN_W-1:0]    gidx,
    output logic                any
);
    logic [PIN_W-1:0] last_q, hi_idx, lo_idx;
    logic             hi_ok;

    always_comb begin
        hi_ok  = 1'b0;
        any    = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                any    = 1'b1;
                lo_idx = PIN_W'(i);
                if (PIN_W'(i) > last_q) begin
                    hi_ok  = 1'b1;
                    hi_idx = PIN_W'(i);
                end
            end
        end
        gidx  = hi_ok ? hi_idx : lo_idx;
        grant = '0;
        if (advance && any) grant[gidx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                 last_q <= PIN_W'(NUM_PINS - 1);
        else if (advance && any) last_q <= gidx;
    end
endmodule

// File: rtl/msgint_node.sv
module msgint_node
    import msgint_pkg::*;
#(
    parameter int NUM_PINS = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                reg_wr,
    input  logic [11:0]         reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [11:0]         msg_dev_id,
    output logic [9:0]          msg_evt_id
);
    localparam int PIN_W = $clog2(NUM_PINS);

    logic [NUM_PINS-1:0] level_sel, clr_hit, grant_vec, pend_vec;
    logic [PIN_W-1:0]    gidx;
    logic                any_req, slot_free;
    vec_t                sel_vec, out_q;
    logic                valid_q;

    assign slot_free = !valid_q || msg_ready;

    msgint_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .level_sel(level_sel),
        .clr_hit(clr_hit), .sel_pin(gidx), .sel_vec(sel_vec)
    );

    msgint_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk(clk), .rst(rst), .irq_in(irq_in), .level_sel(level_sel),
        .clr_hit(clr_hit), .grant(grant_vec), .pending(pend_vec)
    );

    msgint_rr_arb #(.NUM_PINS(NUM_PINS)) u_arb (
        .clk(clk), .rst(rst), .req(pend_vec), .advance(slot_free),
        .grant(grant_vec), .gidx(gidx), .any(any_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else if (slot_free && any_req) begin
            valid_q <= 1'b1;
            out_q   <= sel_vec;
        end else if (msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign msg_valid  = valid_q;
    assign msg_dev_id = out_q.dev;
    assign msg_evt_id = out_q.evt;

endmodule

// File: rtl/msgint_node_chk.sv
module msgint_node_chk #(
    parameter int NUM_PINS = 128
) (
    input logic                clk,
    input logic                rst,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [11:0]         msg_dev_id,
    input logic [9:0]          msg_evt_id,
    input logic [11:0]         reg_addr,
    input logic [31:0]         reg_rdata,
    input logic [NUM_PINS-1:0] grant_vec,
    input logic [NUM_PINS-1:0] pend_vec
);
    localparam logic [11:0] VEC_LO = 12'h200;
    localparam logic [11:0] VEC_HI = 12'(32'h200 + 4 * NUM_PINS);
    localparam logic [11:0] CLR_LO = 12'hA00;
    localparam logic [11:0] CLR_HI = 12'(32'hA00 + NUM_PINS / 8);

    a_r4_hold_payload: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_dev_id) && $stable(msg_evt_id));

    a_r7_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr >= CLR_LO && reg_addr < CLR_HI) |-> reg_rdata == 32'h0);

    a_r3_vec_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr >= VEC_LO && reg_addr < VEC_HI) |-> reg_rdata[31:22] == 10'h0);

    a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec));

    a_r6_grant_needs_pending: assert property (@(posedge clk) disable iff (rst)
        (grant_vec & ~pend_vec) == '0);

endmodule

bind msgint_node msgint_node_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_dev_id(msg_dev_id), .msg_evt_id(msg_evt_id), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .grant_vec(grant_vec), .pend_vec(pend_vec)
);

// File: tb/msgint_node_test.sv
`timescale 1ns/1ps
module msgint_node_test;
    localparam int NP = 128;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] irq_in;
    logic          reg_wr;
    logic [11:0]   reg_addr;
    logic [31:0]   reg_wdata, reg_rdata;
    logic          msg_valid, msg_ready;
    logic [11:0]   msg_dev_id;
    logic [9:0]    msg_evt_id;

    always #4 clk = ~clk;

    msgint_node #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_dev_id(msg_dev_id), .msg_evt_id(msg_evt_id)
    );

    logic [21:0] exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [21:0] vec_of(int p);
        return {10'(32'h3C0 - p), 12'(32'h100 + p)};
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every accepted message.
    always @(negedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected message", {10'b0, msg_evt_id, msg_dev_id}, 32'h0);
            end else begin
                logic [21:0] e;
                e = exp_q.pop_front();
                check({msg_evt_id, msg_dev_id} == e, "R4", "message payload",
                      {10'b0, msg_evt_id, msg_dev_id}, {10'b0, e});
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string req);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, "register read", reg_rdata, exp);
        @(negedge clk);
    endtask

    task automatic pulse(int p);
        irq_in[p] = 1'b1;
        @(negedge clk);
        irq_in[p] = 1'b0;
    endtask

    task automatic drained(string req);
        check(exp_q.size() == 0, req, "messages still expected", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        msg_ready = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd_chk(12'h000, 32'h0, "R1");
        rd_chk(12'h214, 32'h0, "R1");
        check(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);

        // R3 vector programming and readback
        foreach (vec_of_pins[i]) wr(12'(32'h200 + 4 * vec_of_pins[i]), {10'b0, vec_of(vec_of_pins[i])});
        rd_chk(12'h214, {10'b0, vec_of(5)}, "R3");
        wr(12'h3FC, 32'hFFFF_FFFF);
        rd_chk(12'h3FC, 32'h003F_FFFF, "R3");

        // R2 type word for pins 96..127
        wr(12'h00C, 32'h8000_0000);
        rd_chk(12'h00C, 32'h8000_0000, "R2");
        wr(12'h00C, 32'h0);

        // R5 one message per rising edge
        exp_q.push_back(vec_of(5));
        pulse(5);
        idle(6);
        drained("R5");

        // R6 edge while in flight is dropped
        pulse(5);
        idle(6);
        drained("R6");

        // R8 edge pin cleared with input low: silent until new edge
        wr(12'hA00, 32'h20);
        idle(4);
        drained("R8");
        exp_q.push_back(vec_of(5));
        pulse(5);
        idle(6);
        drained("R7");

        // R5 held-high edge pin sends once; R8 clear while high stays silent
        wr(12'hA00, 32'h20);
        exp_q.push_back(vec_of(5));
        irq_in[5] = 1'b1;
        idle(8);
        drained("R5");
        wr(12'hA00, 32'h20);
        idle(6);
        drained("R8");
        irq_in[5] = 1'b0;

        // R9 last grant was pin 5: pin 9 before pin 1
        exp_q.push_back(vec_of(9));
        exp_q.push_back(vec_of(1));
        irq_in[1] = 1'b1; irq_in[9] = 1'b1;
        @(negedge clk);
        irq_in[1] = 1'b0; irq_in[9] = 1'b0;
        idle(8);
        drained("R9");

        // R9 last grant was pin 1: pin 3 before pin 0
        exp_q.push_back(vec_of(3));
        exp_q.push_back(vec_of(0));
        irq_in[0] = 1'b1; irq_in[3] = 1'b1;
        @(negedge clk);
        irq_in[0] = 1'b0; irq_in[3] = 1'b0;
        idle(8);
        drained("R9");

        // R2/R8 level pin 6
        wr(12'h000, 32'h40);
        rd_chk(12'h000, 32'h40, "R2");
        exp_q.push_back(vec_of(6));
        irq_in[6] = 1'b1;
        idle(8);
        drained("R8");
        wr(12'hA00, 32'h0);
        idle(6);
        drained("R7");
        exp_q.push_back(vec_of(6));
        wr(12'hA00, 32'h40);
        idle(8);
        drained("R8");
        irq_in[6] = 1'b0;
        wr(12'hA00, 32'h40);
        idle(6);
        drained("R8");
        rd_chk(12'hA00, 32'h0, "R7");

        // R4 backpressure holds payload
        wr(12'hA00, 32'h01);
        msg_ready = 1'b0;
        pulse(0);
        idle(3);
        check(msg_valid == 1'b1, "R4", "valid under backpressure", msg_valid, 1);
        check({msg_evt_id, msg_dev_id} == vec_of(0), "R4", "payload under backpressure",
              {10'b0, msg_evt_id, msg_dev_id}, {10'b0, vec_of(0)});
        idle(4);
        check(msg_valid == 1'b1 && {msg_evt_id, msg_dev_id} == vec_of(0), "R4",
              "payload still held", {9'b0, msg_valid, msg_evt_id, msg_dev_id}, {10'b1, vec_of(0)});
        exp_q.push_back(vec_of(0));
        msg_ready = 1'b1;
        idle(4);
        drained("R4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    int vec_of_pins[6] = '{0, 1, 3, 5, 6, 9};

endmodule